// File: doc/BRIEF.md
# Boot-Time Memory Controller Register Stub

This block is a small bank of control and status registers that stands in for a DRAM controller while a system boots. Boot firmware writes commands to it and then polls for completion. Every command finishes at once: a request to start memory initialization or data training reads back as done on the next read, and any write to the impedance calibration control word raises a done flag in a separate status word. No DRAM timing, PHY control or memory data path is modelled.

Access goes through a plain 32-bit register bus with a byte address, a write strobe, write data, a read strobe and registered read data. Only three word offsets hold storage. Any other offset reads as zero and raises a one-cycle error pulse. Offsets from 0x2E4 to the end of the decoded window raise the out-of-range pulse. Lower offsets that are not implemented, including addresses that are not word aligned, raise the unimplemented pulse.

Top module: `memctl_boot_stub`

## Requirements
- R1: Synchronous active-low reset loads the command word (offset 0x000) with 0x80020000, the calibration control word (offset 0x0A8) with 0x07B00000 and the calibration status word (offset 0x0B0) with 0x80000000. It also clears the read data and both error pulses to 0.
- R2: A write to offset 0x000 stores bit 31 (start init) and bit 30 (start training) as 0, whatever was written there. It stores bits 29..0 exactly as written.
- R3: A write to offset 0x0A8 stores the written value. In the same cycle it sets bit 31 (calibration done) of the status word at 0x0B0 and leaves status bits 30..0 unchanged.
- R4: A write to offset 0x0B0 stores the written value unchanged.
- R5: Read data appears on the cycle after the read strobe is sampled. In the default build, read data is 0 in any cycle that follows a cycle without a read strobe.
- R6: An access (read or write) at an offset from 0x2E4 up to the top of the address window reads 0. It also raises err_oob for exactly one cycle, in the cycle after the access.
- R7: An access at an offset below 0x2E4 that is not 0x000, 0x0A8 or 0x0B0 reads 0 and raises err_unimp for one cycle, in the cycle after the access. This includes offsets that are not word aligned.
- R8: A write to an unimplemented or out-of-range offset changes none of the three implemented words.
- R9: When a read and a write to the same implemented offset happen in the same cycle, the read returns the value held before that write.
- R10: The two error pulses are never high together. Neither pulse is raised by an access to an implemented offset, or in a cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| err_oob | output | 1 | One-cycle pulse: access at or above the out-of-range start |
| err_unimp | output | 1 | One-cycle pulse: access to an unimplemented offset below it |

## Verification
An address classifier that decodes the wrong class shows up one cycle after the access. The wrong error pulse fires, or a word that should hold a value reads zero. A side effect that is lost or misapplied inside the register bank stays hidden until firmware reads the word back. A missing self-clear on the command word or a missing done flag in the status word therefore shows on the first read after the write, one cycle after that read's strobe. A stray write to an unmapped offset is exposed the same way, by reading back all three words afterwards. The read-before-write ordering shows only on a combined read and write cycle, so the stimulus includes such cycles against the command and status words.

// File: rtl/memctl_stub_pkg.sv
package memctl_stub_pkg;

   localparam int unsigned WORD_W = 32;

   // byte offsets of the implemented words
   localparam int unsigned OFS_CMD    = 32'h000;
   localparam int unsigned OFS_CALCTL = 32'h0A8;
   localparam int unsigned OFS_CALSTS = 32'h0B0;

   // reset images
   localparam logic [WORD_W-1:0] RST_CMD    = 32'h8002_0000;
   localparam logic [WORD_W-1:0] RST_CALCTL = 32'h07B0_0000;
   localparam logic [WORD_W-1:0] RST_CALSTS = 32'h8000_0000;

   // bit positions with side effects
   localparam int unsigned BIT_INIT_REQ  = 31;
   localparam int unsigned BIT_TRAIN_REQ = 30;
   localparam int unsigned BIT_CAL_DONE  = 31;

   typedef enum logic [2:0] {
      K_CMD    = 3'd0,
      K_CALCTL = 3'd1,
      K_CALSTS = 3'd2,
      K_UNIMP  = 3'd3,
      K_OOB    = 3'd4
   } acc_kind_e;

endpackage

// File: rtl/memctl_stub_decode.sv
module memctl_stub_decode
   import memctl_stub_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned OOB_START = 32'h2E4
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);

   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_CALCTL = ADDR_W'(OFS_CALCTL);
   localparam logic [ADDR_W-1:0] A_CALSTS = ADDR_W'(OFS_CALSTS);
   localparam logic [ADDR_W-1:0] A_OOB    = ADDR_W'(OOB_START);

   generate
      if (ADDR_W < 9 || ADDR_W > 20) begin : g_bad_width
         $error("memctl_stub_decode: ADDR_W must lie in 9..20");
      end
      if (OOB_START <= OFS_CALSTS || OOB_START >= (2 ** ADDR_W)) begin : g_bad_oob
         $error("memctl_stub_decode: OOB_START must sit above the status word and inside the window");
      end
   endgenerate

   always_comb begin
      if (addr >= A_OOB) begin
         kind = K_OOB;
      end else begin
         unique case (addr)
            A_CMD:    kind = K_CMD;
            A_CALCTL: kind = K_CALCTL;
            A_CALSTS: kind = K_CALSTS;
            default:  kind = K_UNIMP;
         endcase
      end
   end

endmodule

// File: rtl/memctl_stub_regs.sv
module memctl_stub_regs
   import memctl_stub_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  acc_kind_e         kind,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] cmd_q,
   output logic [WORD_W-1:0] calctl_q,
   output logic [WORD_W-1:0] calsts_q
);

   localparam logic [WORD_W-1:0] SELF_CLR =
      (WORD_W'(1) << BIT_INIT_REQ) | (WORD_W'(1) << BIT_TRAIN_REQ);
   localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << BIT_CAL_DONE;

   logic wr_cmd, wr_calctl, wr_calsts;

   assign wr_cmd    = wr_en && (kind == K_CMD);
   assign wr_calctl = wr_en && (kind == K_CALCTL);
   assign wr_calsts = wr_en && (kind == K_CALSTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= RST_CMD;
         calctl_q <= RST_CALCTL;
         calsts_q <= RST_CALSTS;
      end else begin
         if (wr_cmd)    cmd_q    <= wdata & ~SELF_CLR;
         if (wr_calctl) calctl_q <= wdata;
         if (wr_calsts)      calsts_q <= wdata;
         else if (wr_calctl) calsts_q <= calsts_q | DONE_MASK;
      end
   end

   // R1: reset images present when reset lifts
   p_reset_image_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cmd_q == RST_CMD && calctl_q == RST_CALCTL && calsts_q == RST_CALSTS));

   // R2: request bits read back as complete
   p_cmd_selfclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> (cmd_q[BIT_INIT_REQ] == 1'b0 && cmd_q[BIT_TRAIN_REQ] == 1'b0));

   p_cmd_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> cmd_q[29:0] == $past(wdata[29:0]));

   // R3: calibration write marks done, other status bits untouched
   p_cal_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_calctl |=> (calsts_q[BIT_CAL_DONE] && calsts_q[30:0] == $past(calsts_q[30:0])
                     && calctl_q == $past(wdata)));

   // R4: status word written verbatim
   p_sts_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_calsts |=> calsts_q == $past(wdata));

   // R8: unmapped writes leave all storage alone
   p_unmapped_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (kind == K_UNIMP || kind == K_OOB)) |=>
         ($stable(cmd_q) && $stable(calctl_q) && $stable(calsts_q)));

endmodule

// File: rtl/memctl_stub_rdport.sv
module memctl_stub_rdport
   import memctl_stub_pkg::*;
#(
   parameter bit IDLE_HOLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  acc_kind_e         kind,
   input  logic [WORD_W-1:0] cmd_q,
   input  logic [WORD_W-1:0] calctl_q,
   input  logic [WORD_W-1:0] calsts_q,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] sel_data;

   always_comb begin
      unique case (kind)
         K_CMD:    sel_data = cmd_q;
         K_CALCTL: sel_data = calctl_q;
         K_CALSTS: sel_data = calsts_q;
         default:  sel_data = '0;
      endcase
   end

   generate
      if (IDLE_HOLD) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= sel_data;
         end
      end else begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? sel_data : '0;
         end

         // R5: idle cycle leaves read data at zero
         p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> rdata == '0);
      end
   endgenerate

   // R6 and R7: unmapped reads return zero
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (kind == K_UNIMP || kind == K_OOB)) |=> rdata == '0);

endmodule

// File: rtl/memctl_boot_stub.sv
module memctl_boot_stub
   import memctl_stub_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned OOB_START = 32'h2E4,
   parameter bit          IDLE_HOLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              err_oob,
   output logic              err_unimp
);

   acc_kind_e         kind;
   logic [WORD_W-1:0] cmd_q, calctl_q, calsts_q;
   logic              any_acc;

   memctl_stub_decode #(.ADDR_W(ADDR_W), .OOB_START(OOB_START)) u_decode (
      .addr (bus_addr),
      .kind (kind)
   );

   memctl_stub_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .kind     (kind),
      .wdata    (bus_wdata),
      .cmd_q    (cmd_q),
      .calctl_q (calctl_q),
      .calsts_q (calsts_q)
   );

   memctl_stub_rdport #(.IDLE_HOLD(IDLE_HOLD)) u_rdport (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .kind     (kind),
      .cmd_q    (cmd_q),
      .calctl_q (calctl_q),
      .calsts_q (calsts_q),
      .rdata    (bus_rdata)
   );

   assign any_acc = bus_rd || bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_oob   <= 1'b0;
         err_unimp <= 1'b0;
      end else begin
         err_oob   <= any_acc && (kind == K_OOB);
         err_unimp <= any_acc && (kind == K_UNIMP);
      end
   end

   // R10: pulses exclusive
   p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_oob && err_unimp));

   // R10: mapped or idle cycles raise no flag
   p_flag_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_acc || kind == K_CMD || kind == K_CALCTL || kind == K_CALSTS) |=>
         (!err_oob && !err_unimp));

   // R9: combined read and write returns the prior value
   p_rd_before_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr && kind == K_CMD) |=> bus_rdata == $past(cmd_q));

endmodule

// File: tb/memctl_boot_stub_test.sv
`timescale 1ns/1ps
module memctl_boot_stub_test;

   localparam int ADDR_W = 12;
   localparam int CLK_HALF = 4;

   typedef struct {
      logic [31:0] rdata;
      logic        oob;
      logic        unimp;
      string       req;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic              err_oob, err_unimp;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   exp_t sb_q[$];

   // reference state of the three words
   logic [31:0] m_cmd, m_calctl, m_calsts;

   always #CLK_HALF clk = ~clk;

   memctl_boot_stub #(.ADDR_W(ADDR_W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .err_oob   (err_oob),
      .err_unimp (err_unimp)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
      if (a == 12'h000) return m_cmd;
      if (a == 12'h0A8) return m_calctl;
      if (a == 12'h0B0) return m_calsts;
      return 32'h0;
   endfunction

   // one bus cycle: drive at the falling edge, queue what the next rising edge must yield
   task automatic bus_cycle(input logic [ADDR_W-1:0] a, input bit wr,
                            input logic [31:0] d, input bit rd, input string req);
      exp_t e;
      bit oob, mapped;
      @(negedge clk);
      bus_addr  = a;
      bus_wr    = wr;
      bus_wdata = d;
      bus_rd    = rd;
      oob    = (a >= 12'h2E4);
      mapped = (a == 12'h000) || (a == 12'h0A8) || (a == 12'h0B0);
      e.rdata = rd ? model_read(a) : 32'h0;
      e.oob   = (wr || rd) && oob;
      e.unimp = (wr || rd) && !oob && !mapped;
      e.req   = req;
      sb_q.push_back(e);
      if (wr) begin
         if (a == 12'h000) m_cmd = d & 32'h3FFF_FFFF;
         if (a == 12'h0A8) begin
            m_calctl = d;
            m_calsts = m_calsts | 32'h8000_0000;
         end
         if (a == 12'h0B0) m_calsts = d;
      end
   endtask

   task automatic idle(input string req);
      bus_cycle('0, 1'b0, 32'h0, 1'b0, req);
   endtask

   task automatic read_all(input string req);
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, req);
      bus_cycle(12'h0A8, 1'b0, 32'h0, 1'b1, req);
      bus_cycle(12'h0B0, 1'b0, 32'h0, 1'b1, req);
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(bus_rdata === e.rdata, e.req, "rdata", bus_rdata, e.rdata);
         check(err_oob === e.oob, e.req, "err_oob", 32'(err_oob), 32'(e.oob));
         check(err_unimp === e.unimp, e.req, "err_unimp", 32'(err_unimp), 32'(e.unimp));
      end
   end

   initial begin
      m_cmd    = 32'h8002_0000;
      m_calctl = 32'h07B0_0000;
      m_calsts = 32'h8000_0000;
      repeat (3) @(posedge clk);
      #2;
      // R1: outputs cleared during reset
      check(bus_rdata === 32'h0, "R1", "rdata in reset", bus_rdata, 32'h0);
      check(!err_oob && !err_unimp, "R1", "flags in reset", {30'h0, err_oob, err_unimp}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset images
      read_all("R1");
      idle("R5");

      // R2: request bits self-clear, others kept
      bus_cycle(12'h000, 1'b1, 32'hC000_1234, 1'b0, "R2");
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, "R2");
      bus_cycle(12'h000, 1'b1, 32'h8000_00FF, 1'b0, "R2");
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, "R2");
      bus_cycle(12'h000, 1'b1, 32'h4ABC_0001, 1'b0, "R2");
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, "R2");
      bus_cycle(12'h000, 1'b1, 32'h3FFF_FFFF, 1'b0, "R2");
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, "R2");

      // R4: status written verbatim
      bus_cycle(12'h0B0, 1'b1, 32'h0000_0005, 1'b0, "R4");
      bus_cycle(12'h0B0, 1'b0, 32'h0, 1'b1, "R4");

      // R3: calibration write sets done, keeps low status bits
      bus_cycle(12'h0A8, 1'b1, 32'h1234_5678, 1'b0, "R3");
      read_all("R3");
      bus_cycle(12'h0A8, 1'b1, 32'hFFFF_0000, 1'b0, "R3");
      bus_cycle(12'h0B0, 1'b0, 32'h0, 1'b1, "R3");

      // R5: idle cycles read zero
      idle("R5");
      idle("R5");

      // R9: read and write same word same cycle
      bus_cycle(12'h000, 1'b1, 32'h0000_ABCD, 1'b1, "R9");
      bus_cycle(12'h000, 1'b0, 32'h0, 1'b1, "R9");
      bus_cycle(12'h0B0, 1'b1, 32'h0000_0077, 1'b1, "R9");
      bus_cycle(12'h0B0, 1'b0, 32'h0, 1'b1, "R9");

      // R6: out-of-range window
      bus_cycle(12'h2E4, 1'b0, 32'h0, 1'b1, "R6");
      bus_cycle(12'hFFC, 1'b0, 32'h0, 1'b1, "R6");
      bus_cycle(12'h2E5, 1'b0, 32'h0, 1'b1, "R6");
      idle("R10");
      bus_cycle(12'h300, 1'b1, 32'hFFFF_FFFF, 1'b0, "R6");

      // R7: unimplemented offsets below the window
      bus_cycle(12'h004, 1'b0, 32'h0, 1'b1, "R7");
      bus_cycle(12'h0AC, 1'b0, 32'h0, 1'b1, "R7");
      bus_cycle(12'h002, 1'b0, 32'h0, 1'b1, "R7");
      bus_cycle(12'h2E0, 1'b0, 32'h0, 1'b1, "R7");
      bus_cycle(12'h0AC, 1'b1, 32'hFFFF_FFFF, 1'b0, "R7");
      bus_cycle(12'h001, 1'b1, 32'hFFFF_FFFF, 1'b0, "R7");
      bus_cycle(12'h0A9, 1'b1, 32'h0000_0000, 1'b0, "R7");

      // R8: implemented words untouched by the stray writes
      read_all("R8");
      idle("R10");
      idle("R10");

      @(negedge clk);
      bus_rd = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(2 * CLK_HALF * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule